// File: doc/BRIEF.md
# Receive Frame Page Writer

This block takes one incoming Ethernet frame at a time and lays it out in a 2048-byte page of packet storage. A frame begins with a length word on its own handshake. Its bytes then follow on a valid/ready byte stream, one byte per cycle. The block asks the page allocator for a free page through a request/grant handshake and writes the page through a byte-wide write port. It computes the frame check sequence itself. When the page is complete, it pulses a done strobe that carries the page number. The surrounding controller uses that strobe to push the page onto its receive queue and to set its receive interrupt bit (0x01).

The page begins with a 4-byte header: a little-endian status word, then a little-endian byte count. The payload follows, padded to the minimum frame size, then an optional CRC-32, then two closing bytes. For a frame of odd length longer than the minimum, the last payload byte is held back and written after the CRC, so that the CRC sits on a 16-bit boundary. The closing control byte then encodes the odd length.

A frame is refused in four cases: receive is off, soft reset is active, no page is free, or the page would not fit. A refused frame produces a drop strobe. Its bytes are still consumed, but nothing is written for it.

Top module: `rxw_frame_writer`

## Requirements
- R1: A frame is refused when `rx_en_i` is low, `soft_rst_i` is high, or its page size exceeds PAGE_BYTES. For a refused frame, `drop_o` pulses for one cycle, every byte of the frame is still accepted on the byte stream, and no write and no done pulse follow.
- R2: `alloc_req_o` stays high from frame acceptance until `alloc_gnt_i` or `alloc_full_i` is seen. A grant takes `alloc_page_i` as the target page. A full response refuses the frame as in R1.
- R3: The page size is max(64, length with bit 0 cleared) + 6, plus 4 when `strip_crc_i` is low. It is written little-endian at page bytes 2 and 3.
- R4: Page byte 0 is 0x00. Page byte 1 holds status bit 3 (word bit 11), set for lengths above 1518, and status bit 4 (word bit 12), set for odd lengths.
- R5: From byte 4 on, the payload is written in arrival order. For a frame of odd length at least 64, the last byte is held back and not written in this region.
- R6: A frame shorter than 64 bytes has all its bytes written from byte 4, including an odd last byte, followed by zero bytes up to 64 data bytes (bytes 4 to 67).
- R7: When `strip_crc_i` is low, a CRC-32 follows the data region, least significant byte first. It uses the reflected polynomial 0xEDB88320, an all-ones start value and final inversion, and it covers the padded frame.
- R8: The two closing bytes are the held odd byte then 0x60 for an odd frame of at least 64 bytes, and 0x00 then 0x40 otherwise.
- R9: All writes for an accepted frame go to the granted page at addresses 0 up to page size − 1, in increasing order. After the last write, `done_o` pulses for exactly one cycle with `done_page_o` equal to the granted page.
- R10: After reset the block is ready for a length and holds `alloc_req_o`, `mem_we_o`, `done_o`, `drop_o` and `byte_ready_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enabled |
| soft_rst_i | input | 1 | Soft reset active, refuses frames |
| strip_crc_i | input | 1 | High: no CRC is stored |
| frm_valid_i | input | 1 | Frame length valid |
| frm_len_i | input | LEN_W | Frame length in bytes |
| frm_ready_o | output | 1 | Ready to take a new frame length |
| byte_valid_i | input | 1 | Payload byte valid |
| byte_data_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Payload byte accepted when valid |
| alloc_req_o | output | 1 | Page allocation request |
| alloc_gnt_i | input | 1 | Allocation granted |
| alloc_full_i | input | 1 | No page free |
| alloc_page_i | input | PAGE_W | Granted page number |
| mem_we_o | output | 1 | Page byte write strobe |
| mem_page_o | output | PAGE_W | Page being written |
| mem_addr_o | output | log2(PAGE_BYTES) | Byte address inside the page |
| mem_data_o | output | 8 | Byte to write |
| done_o | output | 1 | One-cycle frame stored strobe |
| done_page_o | output | PAGE_W | Page holding the stored frame |
| drop_o | output | 1 | One-cycle frame refused strobe |

## Verification
The bench builds the block with its defaults: 2048-byte pages, a 64-byte minimum frame, a long-frame limit of 1518, a 12-bit length field and 2-bit page numbers. The 12-bit length lets the bench present frames whose page size lands exactly at 2048 bytes or just above it, so both sides of the size refusal are covered. The four page numbers and a grant delay that varies between frames show that every write follows the grant. Lengths of 0, 1, 60, 61, 63, 64 and 65 exercise the padding and odd-byte placement, and lengths of 1519 and 1520 cross the long-frame flag.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALLOC,
    ST_HDR,
    ST_DATA,
    ST_PAD,
    ST_CRC,
    ST_TAIL,
    ST_DONE,
    ST_DRAIN
  } rxw_state_e;
endpackage

// File: rtl/rxw_crc32.sv
module rxw_crc32 #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  logic [31:0] st_q;
  logic [31:0] nxt;

  always_comb begin
    nxt = st_q ^ {24'h0, data_i};
    for (int b = 0; b < 8; b++) begin
      nxt = nxt[0] ? ((nxt >> 1) ^ POLY) : (nxt >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '1;
    else if (init_i) st_q <= '1;
    else if (en_i)   st_q <= nxt;
  end

  assign crc_o = ~st_q;
endmodule

// File: rtl/rxw_sizer.sv
module rxw_sizer #(
  parameter int LEN_W      = 12,
  parameter int PS_W       = 16,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  parameter int PAGE_BYTES = 2048
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             strip_i,
  output logic [PS_W-1:0]  psize_o,
  output logic             long_o,
  output logic             odd_o,
  output logic             short_o,
  output logic             too_big_o
);
  logic [PS_W-1:0] even_len;
  logic [PS_W-1:0] body;

  assign even_len  = PS_W'({len_i[LEN_W-1:1], 1'b0});
  assign body      = (even_len < PS_W'(MIN_FRAME)) ? PS_W'(MIN_FRAME) : even_len;
  assign psize_o   = body + PS_W'(6) + (strip_i ? PS_W'(0) : PS_W'(4));
  assign long_o    = len_i > LEN_W'(LONG_LIMIT);
  assign odd_o     = len_i[0];
  assign short_o   = len_i < LEN_W'(MIN_FRAME);
  assign too_big_o = psize_o > PS_W'(PAGE_BYTES);
endmodule

// File: rtl/rxw_frame_writer.sv
module rxw_frame_writer
  import rxw_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGE_W     = 2,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              soft_rst_i,
  input  logic              strip_crc_i,
  input  logic              frm_valid_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  output logic              frm_ready_o,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              alloc_req_o,
  input  logic              alloc_gnt_i,
  input  logic              alloc_full_i,
  input  logic [PAGE_W-1:0] alloc_page_i,
  output logic              mem_we_o,
  output logic [PAGE_W-1:0] mem_page_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic              done_o,
  output logic [PAGE_W-1:0] done_page_o,
  output logic              drop_o
);
  localparam int PS_W = 16;

  rxw_state_e        state_q, state_d;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [1:0]        beat_q;
  logic [7:0]        odd_byte_q;
  logic [PAGE_W-1:0] page_q;
  logic [PS_W-1:0]   psize_q;
  logic              crc_on_q, long_q, odd_q, short_q;

  logic [PS_W-1:0]   sz_psize;
  logic              sz_long, sz_odd, sz_short, sz_big;
  logic              crc_init, crc_en;
  logic [7:0]        crc_din;
  logic [31:0]       crc_val;

  logic accept, byte_take, last_byte, odd_tail, hold_odd, cfg_refuse;

  rxw_sizer #(
    .LEN_W(LEN_W), .PS_W(PS_W), .MIN_FRAME(MIN_FRAME),
    .LONG_LIMIT(LONG_LIMIT), .PAGE_BYTES(PAGE_BYTES)
  ) u_sizer (
    .len_i(frm_len_i), .strip_i(strip_crc_i), .psize_o(sz_psize),
    .long_o(sz_long), .odd_o(sz_odd), .short_o(sz_short), .too_big_o(sz_big)
  );

  rxw_crc32 u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(crc_init), .en_i(crc_en),
    .data_i(crc_din), .crc_o(crc_val)
  );

  assign frm_ready_o  = (state_q == ST_IDLE);
  assign byte_ready_o = (state_q == ST_DATA) || (state_q == ST_DRAIN);
  assign alloc_req_o  = (state_q == ST_ALLOC);
  assign done_o       = (state_q == ST_DONE);
  assign done_page_o  = page_q;
  assign mem_page_o   = page_q;
  assign mem_addr_o   = waddr_q;

  assign accept     = frm_valid_i && frm_ready_o;
  assign byte_take  = byte_valid_i && byte_ready_o;
  assign last_byte  = (idx_q == len_q - LEN_W'(1));
  assign odd_tail   = odd_q && !short_q;
  assign hold_odd   = odd_tail && last_byte;
  assign cfg_refuse = !rx_en_i || soft_rst_i || sz_big;
  assign crc_init   = accept;

  always_comb begin
    state_d    = state_q;
    mem_we_o   = 1'b0;
    mem_data_o = 8'h00;
    drop_o     = 1'b0;
    crc_en     = 1'b0;
    crc_din    = 8'h00;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cfg_refuse) begin
            drop_o  = 1'b1;
            state_d = (frm_len_i == '0) ? ST_IDLE : ST_DRAIN;
          end else begin
            state_d = ST_ALLOC;
          end
        end
      end
      ST_ALLOC: begin
        if (alloc_gnt_i) begin
          state_d = ST_HDR;
        end else if (alloc_full_i) begin
          drop_o  = 1'b1;
          state_d = (len_q == '0) ? ST_IDLE : ST_DRAIN;
        end
      end
      ST_HDR: begin
        mem_we_o = 1'b1;
        case (beat_q)
          2'd0:    mem_data_o = 8'h00;
          2'd1:    mem_data_o = {3'b000, odd_q, long_q, 3'b000};
          2'd2:    mem_data_o = psize_q[7:0];
          default: mem_data_o = psize_q[15:8];
        endcase
        if (beat_q == 2'd3) state_d = (len_q == '0) ? ST_PAD : ST_DATA;
      end
      ST_DATA: begin
        mem_data_o = byte_data_i;
        if (byte_take) begin
          crc_en   = 1'b1;
          crc_din  = byte_data_i;
          mem_we_o = !hold_odd;
          if (last_byte) state_d = short_q ? ST_PAD : (crc_on_q ? ST_CRC : ST_TAIL);
        end
      end
      ST_PAD: begin
        mem_we_o = 1'b1;
        crc_en   = 1'b1;
        if (idx_q == LEN_W'(MIN_FRAME - 1)) state_d = crc_on_q ? ST_CRC : ST_TAIL;
      end
      ST_CRC: begin
        mem_we_o   = 1'b1;
        mem_data_o = crc_val[{beat_q, 3'b000} +: 8];
        if (beat_q == 2'd3) state_d = ST_TAIL;
      end
      ST_TAIL: begin
        mem_we_o = 1'b1;
        if (beat_q == 2'd0) mem_data_o = odd_tail ? odd_byte_q : 8'h00;
        else                mem_data_o = odd_tail ? 8'h60 : 8'h40;
        if (beat_q == 2'd1) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_DRAIN: if (byte_take && last_byte) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      len_q      <= '0;
      idx_q      <= '0;
      waddr_q    <= '0;
      beat_q     <= '0;
      odd_byte_q <= '0;
      page_q     <= '0;
      psize_q    <= '0;
      crc_on_q   <= 1'b0;
      long_q     <= 1'b0;
      odd_q      <= 1'b0;
      short_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= (state_d != state_q) ? 2'd0 : beat_q + 2'd1;
      if (mem_we_o) waddr_q <= waddr_q + ADDR_W'(1);
      case (state_q)
        ST_IDLE: if (accept) begin
          len_q    <= frm_len_i;
          psize_q  <= sz_psize;
          long_q   <= sz_long;
          odd_q    <= sz_odd;
          short_q  <= sz_short;
          crc_on_q <= !strip_crc_i;
          idx_q    <= '0;
          waddr_q  <= '0;
        end
        ST_ALLOC: if (alloc_gnt_i) page_q <= alloc_page_i;
        ST_DATA: if (byte_take) begin
          idx_q <= idx_q + LEN_W'(1);
          if (hold_odd) odd_byte_q <= byte_data_i;
        end
        ST_DRAIN: if (byte_take) idx_q <= idx_q + LEN_W'(1);
        ST_PAD:   idx_q <= idx_q + LEN_W'(1);
        default: ;
      endcase
    end
  end

  // R2: request held until answered
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_o && !alloc_gnt_i && !alloc_full_i |=> alloc_req_o);

  // R1: a refusal is not followed by a write
  p_drop_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !mem_we_o);

  // R9: back-to-back writes walk the page one byte at a time
  p_addr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + ADDR_W'(1)));

  p_page_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> $stable(mem_page_o));

  // R3: last write lands on page size - 1
  p_done_size_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o) && (32'($past(mem_addr_o)) + 32'd1 == 32'(psize_q)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/rxw_frame_writer_tb.sv
`timescale 1ns/1ps
module rxw_frame_writer_tb;
  localparam int LEN_W = 12;
  localparam int PAGE_W = 2;
  localparam int ADDR_W = 11;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_en_i = 1'b0, soft_rst_i = 1'b0, strip_crc_i = 1'b0;
  logic frm_valid_i = 1'b0;
  logic [LEN_W-1:0] frm_len_i = '0;
  logic frm_ready_o;
  logic byte_valid_i = 1'b0;
  logic [7:0] byte_data_i = '0;
  logic byte_ready_o, alloc_req_o;
  logic alloc_gnt_i = 1'b0, alloc_full_i = 1'b0;
  logic [PAGE_W-1:0] alloc_page_i = '0;
  logic mem_we_o;
  logic [PAGE_W-1:0] mem_page_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [7:0] mem_data_o;
  logic done_o, drop_o;
  logic [PAGE_W-1:0] done_page_o;

  rxw_frame_writer u_dut (
    .clk_i, .rst_ni, .rx_en_i, .soft_rst_i, .strip_crc_i,
    .frm_valid_i, .frm_len_i, .frm_ready_o,
    .byte_valid_i, .byte_data_i, .byte_ready_o,
    .alloc_req_o, .alloc_gnt_i, .alloc_full_i, .alloc_page_i,
    .mem_we_o, .mem_page_o, .mem_addr_o, .mem_data_o,
    .done_o, .done_page_o, .drop_o
  );

  always #2.5 clk_i = ~clk_i;

  int tests = 0, fails = 0;
  logic [7:0] got [0:2047];
  logic [7:0] expm [0:2047];
  int wr_cnt, done_cnt, drop_cnt, page_err;
  logic [PAGE_W-1:0] done_pg, exp_page;
  bit req_seen, stream_to;
  int gnt_delay = 0, req_wait = 0;
  bit full_mode = 1'b0;

  typedef struct packed {
    int len; int seed; bit strip; int dly; int pg;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{64,   17, 1'b0, 0, 1},
    '{65,   3,  1'b0, 2, 2},
    '{60,   90, 1'b0, 1, 3},
    '{61,   5,  1'b0, 0, 0},
    '{1,    200,1'b1, 3, 1},
    '{0,    0,  1'b0, 0, 2},
    '{100,  44, 1'b1, 1, 3},
    '{1519, 9,  1'b0, 0, 0},
    '{1520, 77, 1'b1, 2, 1},
    '{2042, 31, 1'b1, 0, 2},
    '{63,   12, 1'b0, 4, 3}
  };

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed + k * 7);
  endfunction

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    #2;
    if (rst_ni) begin
      if (mem_we_o) begin
        got[mem_addr_o] = mem_data_o;
        wr_cnt++;
        if (mem_page_o != exp_page) page_err++;
      end
      if (done_o) begin done_cnt++; done_pg = done_page_o; end
      if (drop_o) drop_cnt++;
      if (alloc_req_o) req_seen = 1'b1;
    end
  end

  always @(negedge clk_i) begin
    alloc_gnt_i = 1'b0;
    alloc_full_i = 1'b0;
    if (alloc_req_o) begin
      if (req_wait >= gnt_delay) begin
        if (full_mode) alloc_full_i = 1'b1;
        else alloc_gnt_i = 1'b1;
        req_wait = 0;
      end else req_wait++;
    end
  end

  task automatic run_frame(int len, int seed, bit strip, bit en, bit srst,
                           bit full, int dly, int pg);
    int k, t;
    bit gap;
    for (int a = 0; a < 2048; a++) got[a] = 8'hA5;
    wr_cnt = 0; done_cnt = 0; drop_cnt = 0; page_err = 0;
    req_seen = 1'b0; stream_to = 1'b0;
    exp_page = PAGE_W'(pg); alloc_page_i = PAGE_W'(pg);
    gnt_delay = dly; full_mode = full; req_wait = 0;
    rx_en_i = en; soft_rst_i = srst; strip_crc_i = strip;
    @(negedge clk_i);
    frm_valid_i = 1'b1; frm_len_i = LEN_W'(len);
    #0.1;
    t = 0;
    while (!frm_ready_o && t < 1000) begin @(negedge clk_i); #0.1; t++; end
    @(negedge clk_i);
    frm_valid_i = 1'b0;
    k = 0; t = 0; gap = 1'b0;
    while (k < len && t < 20000) begin
      if (t != 0) @(negedge clk_i);
      t++;
      if (k % 11 == 5 && !gap) begin
        byte_valid_i = 1'b0; gap = 1'b1;
      end else begin
        byte_valid_i = 1'b1; byte_data_i = pat(seed, k);
        #0.1;
        if (byte_ready_o) begin k++; gap = 1'b0; end
      end
    end
    if (k < len) stream_to = 1'b1;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    t = 0;
    while (done_cnt == 0 && drop_cnt == 0 && t < 400) begin @(negedge clk_i); t++; end
    repeat (3) @(negedge clk_i);
  endtask

  task automatic check_frame(int len, int seed, bit strip, int pg);
    int even, body, nd, ps, pos, lim;
    bit shrt;
    logic [31:0] c;
    int mm [5];
    logic [7:0] fa [5], fe [5];
    int reg_of [0:2047];
    shrt = (len < 64);
    even = len & ~1;
    body = (even < 64) ? 64 : even;
    ps = body + 6 + (strip ? 0 : 4);
    nd = shrt ? 64 : even;
    expm[0] = 8'h00;
    expm[1] = 8'((len > 1518 ? 8 : 0) | ((len & 1) != 0 ? 16 : 0));
    expm[2] = 8'(ps & 255);
    expm[3] = 8'(ps >> 8);
    reg_of[0] = 0; reg_of[1] = 0; reg_of[2] = 1; reg_of[3] = 1;
    for (int i = 0; i < nd; i++) begin
      expm[4 + i] = (i < len) ? pat(seed, i) : 8'h00;
      reg_of[4 + i] = 2;
    end
    lim = shrt ? 64 : len;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < lim; i++) c = crc_step(c, (i < len) ? pat(seed, i) : 8'h00);
    c = ~c;
    pos = 4 + nd;
    if (!strip) begin
      for (int b = 0; b < 4; b++) begin expm[pos + b] = c[8*b +: 8]; reg_of[pos + b] = 3; end
      pos += 4;
    end
    if ((len & 1) != 0 && !shrt) begin
      expm[pos] = pat(seed, len - 1); expm[pos + 1] = 8'h60;
    end else begin
      expm[pos] = 8'h00; expm[pos + 1] = 8'h40;
    end
    reg_of[pos] = 4; reg_of[pos + 1] = 4;
    for (int r = 0; r < 5; r++) begin mm[r] = 0; fa[r] = 0; fe[r] = 0; end
    for (int a = 0; a < ps && a < 2048; a++) begin
      if (got[a] !== expm[a]) begin
        if (mm[reg_of[a]] == 0) begin fa[reg_of[a]] = got[a]; fe[reg_of[a]] = expm[a]; end
        mm[reg_of[a]]++;
      end
    end
    chk(mm[0] == 0, "R4", $sformatf("status len=%0d", len), fa[0], fe[0]);
    chk(mm[1] == 0, "R3", $sformatf("size bytes len=%0d", len), fa[1], fe[1]);
    if (shrt) chk(mm[2] == 0, "R6", $sformatf("padded data len=%0d", len), fa[2], fe[2]);
    else      chk(mm[2] == 0, "R5", $sformatf("payload len=%0d", len), fa[2], fe[2]);
    if (!strip) chk(mm[3] == 0, "R7", $sformatf("crc len=%0d", len), fa[3], fe[3]);
    chk(mm[4] == 0, "R8", $sformatf("trailer len=%0d", len), fa[4], fe[4]);
    chk(wr_cnt == ps, "R9", $sformatf("write count len=%0d", len), wr_cnt, ps);
    chk(done_cnt == 1 && done_pg == PAGE_W'(pg), "R9",
        $sformatf("done page len=%0d", len), {done_cnt, 2'(done_pg)}, {1, 2'(pg)});
    chk(page_err == 0 && drop_cnt == 0, "R2", $sformatf("granted page used len=%0d", len),
        page_err, 0);
  endtask

  task automatic check_drop(string why, bit want_req);
    chk(drop_cnt == 1, "R1", {why, " drop pulse"}, drop_cnt, 1);
    chk(wr_cnt == 0 && done_cnt == 0, "R1", {why, " no writes"}, wr_cnt + done_cnt, 0);
    chk(!stream_to, "R1", {why, " bytes drained"}, stream_to, 0);
    if (want_req) chk(req_seen, "R2", {why, " request issued"}, req_seen, 1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(frm_ready_o == 1'b1, "R10", "ready in reset", frm_ready_o, 1);
    chk({alloc_req_o, mem_we_o, done_o, drop_o, byte_ready_o} == 5'b0, "R10",
        "quiet outputs", {alloc_req_o, mem_we_o, done_o, drop_o, byte_ready_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(frm_ready_o && !alloc_req_o && !byte_ready_o, "R10", "after release",
        {frm_ready_o, alloc_req_o, byte_ready_o}, 3'b100);

    for (int v = 0; v < 11; v++) begin
      run_frame(VECS[v].len, VECS[v].seed, VECS[v].strip, 1'b1, 1'b0, 1'b0,
                VECS[v].dly, VECS[v].pg);
      check_frame(VECS[v].len, VECS[v].seed, VECS[v].strip, VECS[v].pg);
    end

    run_frame(20, 1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1);
    check_drop("rx off", 1'b0);
    run_frame(70, 2, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1);
    check_drop("soft reset", 1'b0);
    run_frame(2040, 3, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1);
    check_drop("oversize", 1'b0);
    run_frame(30, 4, 1'b0, 1'b1, 1'b0, 1'b1, 2, 1);
    check_drop("no page", 1'b1);
    run_frame(2039, 6, 1'b0, 1'b1, 1'b0, 1'b0, 1, 0);
    check_frame(2039, 6, 1'b0, 0);
    run_frame(65, 8, 1'b1, 1'b1, 1'b0, 1'b0, 3, 3);
    check_frame(65, 8, 1'b1, 3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule